// File: doc/BRIEF.md
# Overlapped Word Copy Engine

This block moves a run of 32-bit words from a source buffer to a destination buffer through one TL-UL host port. A controller loads a source address, a destination address and a byte count, then pulses `start`. The engine sends Get requests for source words and places the returned data in a small synchronous FIFO. It drains that FIFO with PutFullData requests to the destination. Reads and writes are in flight at the same time, so the A channel carries traffic every cycle that the bus accepts it.

Two tags on `a_source` tell the responses apart. Each D-channel beat goes to the read side or the write side according to `d_source`. A read is sent only while the FIFO entries plus the reads still in flight leave room for the returning word, so `d_ready` never has to drop. Live source, destination and remaining-length values are visible at all times. A one-cycle `done` marks a completed copy. `abort` or an error response ends the copy early. The engine then drains any outstanding responses and goes idle.

The control is one state machine with three states. IDLE waits for work; the transition *launch* (start seen) goes to COPY. COPY issues traffic. The transition *finish* (every write acknowledged) returns to IDLE with `done`, and the transition *cancel* (abort, or a response with `d_error`) goes to FLUSH. FLUSH issues nothing and accepts responses; the transition *drained* (no read or write outstanding) returns to IDLE.

Top module: `pcopy_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `done`, `err` and `a_valid` are 0, and `cur_src`, `cur_dst` and `remaining` are 0. While idle, `a_valid` stays 0.
- R2: A read request has `a_opcode`=4 (Get) and `a_source`=0. A write request has `a_opcode`=0 (PutFullData), `a_source`=1, and `a_data` set to the source word of the same index. Every request has `a_mask`=4'hF and `a_size`=2. The k-th read goes to src+4k and the k-th write goes to dst+4k.
- R3: For any byte count that is a multiple of 4, the destination words end up equal to the source words, and the word after the buffer is untouched. A count of 0 completes with `done` and makes no request.
- R4: `cur_src` rises by 4 on each accepted read. `cur_dst` rises by 4 on each accepted write. `remaining` starts at the byte count and falls by 4 on each write acknowledge.
- R5: `done` is high for exactly one cycle, the cycle after the last write acknowledge. `busy` is 0 in the following cycle.
- R6: The FIFO entries plus the reads in flight never exceed DEPTH. Accepted reads never lead accepted writes by more than DEPTH. `d_ready` is 1 while busy.
- R7: When a read and a write are both pending and one is accepted, the other kind is offered next if both are still pending. Writes start before the last read on copies longer than DEPTH.
- R8: A request that is offered and not accepted is offered again unchanged in the next cycle, unless the copy was cancelled.
- R9: `abort` during a copy stops new requests from the next cycle. The engine drains outstanding responses, goes idle without `done`, and leaves `err` at 0. `abort` while idle has no effect.
- R10: A response with `d_error`=1 cancels the copy like abort, but sets `err`. `err` stays 1 until the next start and no `done` is given.
- R11: `start` while busy is ignored. The running copy continues with its original addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a copy (taken only when idle) |
| src_addr | input | AW | First source byte address, word aligned |
| dst_addr | input | AW | First destination byte address, word aligned |
| byte_len | input | LEN_W | Bytes to copy, multiple of 4 |
| abort | input | 1 | Cancel the running copy |
| busy | output | 1 | Engine not idle |
| done | output | 1 | One-cycle pulse on normal completion |
| err | output | 1 | Last copy ended by an error response |
| cur_src | output | AW | Next source address to read |
| cur_dst | output | AW | Next destination address to write |
| remaining | output | LEN_W | Bytes not yet acknowledged |
| a_valid | output | 1 | A-channel request valid |
| a_ready | input | 1 | A-channel request accepted |
| a_opcode | output | 3 | Get or PutFullData |
| a_address | output | AW | Request address |
| a_data | output | DW | Write data |
| a_mask | output | DW/8 | Byte mask, all ones |
| a_size | output | 2 | log2 of transfer bytes (2) |
| a_source | output | SRC_W | Request tag (read or write) |
| d_valid | input | 1 | D-channel response valid |
| d_ready | output | 1 | D-channel response accepted |
| d_data | input | DW | Read response data |
| d_source | input | SRC_W | Tag of the request answered |
| d_error | input | 1 | Response reports an error |

## Verification
The copy is swept over word counts from 0 to 9 and checked against three A-channel acceptance patterns and two response latencies. Always-ready with short latency shows that reads and writes interleave and that read issue is throttled by the FIFO credit. Alternating and irregular acceptance exercise the rule that a stalled request is held unchanged. Longer latency fills the credit window and exposes any FIFO overflow or a stalled `d_ready`. Separate runs inject an abort in mid-copy, an abort while idle, a response with an error, and a second start during a copy; each one separates cancel and drain behaviour from normal completion.

// File: rtl/pcopy_pkg.sv
package pcopy_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COPY  = 2'd1,
        ST_FLUSH = 2'd2
    } eng_state_e;

    localparam logic [2:0] TL_OP_GET      = 3'd4;
    localparam logic [2:0] TL_OP_PUT_FULL = 3'd0;

endpackage

// File: rtl/pcopy_fifo.sv
module pcopy_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count,
    output logic          empty
);
    logic [DW-1:0] slots [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push && !clr) slots[wr_ptr] <= wdata;
    end

    assign rdata = slots[rd_ptr];
    assign empty = (count == '0);
endmodule

// File: rtl/pcopy_arb.sv
module pcopy_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic wr_req,
    input  logic a_ready,
    output logic gnt_rd,
    output logic gnt_wr
);
    logic pref_wr;
    logic hold_v;
    logic hold_wr;

    always_comb begin
        if (hold_v) begin
            gnt_wr = hold_wr && wr_req;
            gnt_rd = !hold_wr && rd_req;
        end else if (rd_req && wr_req) begin
            gnt_wr = pref_wr;
            gnt_rd = !pref_wr;
        end else begin
            gnt_wr = wr_req;
            gnt_rd = rd_req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pref_wr <= 1'b0;
            hold_v  <= 1'b0;
            hold_wr <= 1'b0;
        end else begin
            hold_v  <= (gnt_rd || gnt_wr) && !a_ready;
            hold_wr <= gnt_wr;
            if ((gnt_rd || gnt_wr) && a_ready) pref_wr <= gnt_rd;
        end
    end
endmodule

// File: rtl/pcopy_engine.sv
module pcopy_engine
    import pcopy_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int LEN_W  = 32,
    parameter int DEPTH  = 4,
    parameter int SRC_W  = 2,
    parameter int RD_TAG = 0,
    parameter int WR_TAG = 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [AW-1:0]      src_addr,
    input  logic [AW-1:0]      dst_addr,
    input  logic [LEN_W-1:0]   byte_len,
    input  logic               abort,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [AW-1:0]      cur_src,
    output logic [AW-1:0]      cur_dst,
    output logic [LEN_W-1:0]   remaining,
    output logic               a_valid,
    input  logic               a_ready,
    output logic [2:0]         a_opcode,
    output logic [AW-1:0]      a_address,
    output logic [DW-1:0]      a_data,
    output logic [DW/8-1:0]    a_mask,
    output logic [1:0]         a_size,
    output logic [SRC_W-1:0]   a_source,
    input  logic               d_valid,
    output logic               d_ready,
    input  logic [DW-1:0]      d_data,
    input  logic [SRC_W-1:0]   d_source,
    input  logic               d_error
);
    localparam logic [SRC_W-1:0] RD_ID   = SRC_W'(RD_TAG);
    localparam logic [SRC_W-1:0] WR_ID   = SRC_W'(WR_TAG);
    localparam logic [CW:0]      DEPTH_C = (CW + 1)'(DEPTH);

    eng_state_e state, state_nx;

    logic [LEN_W-1:0] total_q, rd_cnt, wr_cnt, ack_cnt;
    logic [LEN_W-1:0] words_in;
    logic [AW-1:0]    src_q, dst_q;
    logic [LEN_W-1:0] rem_q;
    logic [CW-1:0]    rd_infl;
    logic             err_q;

    logic [CW-1:0]    fifo_cnt;
    logic             fifo_empty;
    logic [DW-1:0]    fifo_head;
    logic             rd_req, wr_req, gnt_rd, gnt_wr;
    logic             rd_fire, wr_fire, d_rd, d_wr, fifo_push, launch;

    assign words_in  = byte_len >> 2;
    assign launch    = start && (state == ST_IDLE);
    assign rd_req    = (state == ST_COPY) && (rd_cnt != total_q) &&
                       (({1'b0, fifo_cnt} + {1'b0, rd_infl}) < DEPTH_C);
    assign wr_req    = (state == ST_COPY) && !fifo_empty;
    assign rd_fire   = gnt_rd && a_ready;
    assign wr_fire   = gnt_wr && a_ready;
    assign d_rd      = d_valid && (d_source == RD_ID);
    assign d_wr      = d_valid && (d_source == WR_ID);
    assign fifo_push = d_rd && !d_error && (state == ST_COPY);

    pcopy_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (launch),
        .push  (fifo_push),
        .wdata (d_data),
        .pop   (wr_fire),
        .rdata (fifo_head),
        .count (fifo_cnt),
        .empty (fifo_empty)
    );

    pcopy_arb u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (rd_req),
        .wr_req  (wr_req),
        .a_ready (a_ready),
        .gnt_rd  (gnt_rd),
        .gnt_wr  (gnt_wr)
    );

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_COPY;
            ST_COPY: begin
                if (ack_cnt == total_q)             state_nx = ST_IDLE;
                else if (abort || (d_valid && d_error)) state_nx = ST_FLUSH;
            end
            ST_FLUSH: if (rd_infl == '0 && wr_cnt == ack_cnt) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath counters and live values
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total_q <= '0;
            rd_cnt  <= '0;
            wr_cnt  <= '0;
            ack_cnt <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            rem_q   <= '0;
            rd_infl <= '0;
            err_q   <= 1'b0;
        end else if (launch) begin
            total_q <= words_in;
            rd_cnt  <= '0;
            wr_cnt  <= '0;
            ack_cnt <= '0;
            src_q   <= src_addr;
            dst_q   <= dst_addr;
            rem_q   <= byte_len;
            rd_infl <= '0;
            err_q   <= 1'b0;
        end else begin
            if (rd_fire) begin
                rd_cnt <= rd_cnt + LEN_W'(1);
                src_q  <= src_q + AW'(4);
            end
            if (wr_fire) begin
                wr_cnt <= wr_cnt + LEN_W'(1);
                dst_q  <= dst_q + AW'(4);
            end
            if (d_wr) begin
                ack_cnt <= ack_cnt + LEN_W'(1);
                rem_q   <= rem_q - LEN_W'(4);
            end
            case ({rd_fire, d_rd})
                2'b10:   rd_infl <= rd_infl + CW'(1);
                2'b01:   rd_infl <= rd_infl - CW'(1);
                default: rd_infl <= rd_infl;
            endcase
            if (d_valid && d_error && state != ST_IDLE) err_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_COPY) && (ack_cnt == total_q);
        err       = err_q;
        cur_src   = src_q;
        cur_dst   = dst_q;
        remaining = rem_q;
        a_valid   = gnt_rd || gnt_wr;
        a_opcode  = gnt_wr ? TL_OP_PUT_FULL : TL_OP_GET;
        a_address = gnt_wr ? dst_q : src_q;
        a_data    = gnt_wr ? fifo_head : '0;
        a_mask    = '1;
        a_size    = 2'd2;
        a_source  = gnt_wr ? WR_ID : RD_ID;
        d_ready   = 1'b1;
    end
endmodule

// File: rtl/pcopy_engine_chk.sv
module pcopy_engine_chk
    import pcopy_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int LEN_W  = 32,
    parameter int DEPTH  = 4,
    parameter int SRC_W  = 2,
    parameter int RD_TAG = 0,
    parameter int WR_TAG = 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             abort,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic [LEN_W-1:0] remaining,
    input logic             a_valid,
    input logic             a_ready,
    input logic [2:0]       a_opcode,
    input logic [AW-1:0]    a_address,
    input logic [DW-1:0]    a_data,
    input logic [DW/8-1:0]  a_mask,
    input logic [1:0]       a_size,
    input logic [SRC_W-1:0] a_source,
    input logic             d_valid,
    input logic             d_ready,
    input logic [SRC_W-1:0] d_source,
    input logic             d_error,
    input logic [CW-1:0]    fifo_cnt,
    input logic [CW-1:0]    rd_infl,
    input logic             rd_req,
    input logic             wr_req,
    input logic             gnt_rd,
    input logic             gnt_wr
);
    localparam logic [SRC_W-1:0] RD_ID = SRC_W'(RD_TAG);
    localparam logic [SRC_W-1:0] WR_ID = SRC_W'(WR_TAG);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !a_valid); // R1

    AST_REQ_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        a_valid |-> (((a_opcode == TL_OP_GET) && (a_source == RD_ID)) ||
                     ((a_opcode == TL_OP_PUT_FULL) && (a_source == WR_ID))) &&
                    (a_mask == '1) && (a_size == 2'd2)); // R2

    AST_REM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && d_valid && d_ready && d_source == WR_ID) |=>
            (remaining == $past(remaining) - LEN_W'(4))); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, fifo_cnt} + {1'b0, rd_infl}) <= (CW + 1)'(DEPTH)); // R6

    AST_D_READY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> d_ready); // R6

    AST_ALT_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (a_ready && gnt_wr && rd_req && wr_req) |=> (!(rd_req && wr_req) || gnt_rd)); // R7

    AST_ALT_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (a_ready && gnt_rd && rd_req && wr_req) |=> (!(rd_req && wr_req) || gnt_wr)); // R7

    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && !a_ready && !abort && !(d_valid && d_error)) |=>
            (a_valid && $stable(a_address) && $stable(a_opcode) && $stable(a_data))); // R8

    AST_ABORT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort && !done) |=> !a_valid); // R9

    AST_ERR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && d_valid && d_error && !done) |=> (!a_valid && err)); // R10
endmodule

bind pcopy_engine pcopy_engine_chk #(
    .AW(AW), .DW(DW), .LEN_W(LEN_W), .DEPTH(DEPTH),
    .SRC_W(SRC_W), .RD_TAG(RD_TAG), .WR_TAG(WR_TAG)
) u_chk (.*);

// File: tb/tb_pcopy_engine.sv
module tb_pcopy_engine;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, abort = 1'b0;
    logic [31:0] src_addr = '0, dst_addr = '0, byte_len = '0;
    logic        busy, done, err;
    logic [31:0] cur_src, cur_dst, remaining;
    logic        a_valid, a_ready = 1'b0;
    logic [2:0]  a_opcode;
    logic [31:0] a_address, a_data;
    logic [3:0]  a_mask;
    logic [1:0]  a_size, a_source;
    logic        d_valid = 1'b0, d_ready, d_error = 1'b0;
    logic [31:0] d_data = '0;
    logic [1:0]  d_source = '0;

    always #5 clk = ~clk;

    pcopy_engine dut (.*);

    int n_checks = 0, n_errs = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    logic [31:0] mem [256];
    function automatic logic [31:0] pat(input int i);
        return (i * 32'h9E37_79B1) ^ 32'h5A5A_0000 ^ i;
    endfunction

    // bus model state
    int cyc = 0;
    int rdy_mode = 0, lat = 1, err_at = -1;
    logic pv = 0, pr = 0, abort_prev = 0, err_prev = 0, dp = 0, dp_wr = 0;
    logic [2:0]  p_op;
    logic [31:0] p_addr, p_data;
    logic        q_wr [64];
    logic [31:0] q_d [64];
    int          q_t [64];
    int qh = 0, qt = 0;
    int rd_f = 0, wr_f = 0, wr_ack = 0, resp_n = 0, done_seen = 0;
    int first_wr_at = -1, last_rd_at = -1;
    logic track = 0, prev_done = 0;
    logic [31:0] t_src = 0, t_dst = 0, t_len = 0;

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_errs++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
        if (rst_n) begin
            if (dp && dp_wr) wr_ack++;
            if (pv && pr) begin
                if (p_op == 3'd4) begin
                    chk(p_addr == t_src + 4*rd_f, "R2", "read address", p_addr, t_src + 4*rd_f);
                    q_wr[qt] = 1'b0; q_d[qt] = mem[p_addr[9:2]]; q_t[qt] = cyc; qt = (qt + 1) % 64;
                    rd_f++; last_rd_at = cyc;
                end else begin
                    chk(p_addr == t_dst + 4*wr_f, "R2", "write address", p_addr, t_dst + 4*wr_f);
                    chk(p_data == pat(t_src[9:2] + wr_f), "R2", "write data", p_data, pat(t_src[9:2] + wr_f));
                    mem[p_addr[9:2]] = p_data;
                    q_wr[qt] = 1'b1; q_d[qt] = '0; q_t[qt] = cyc; qt = (qt + 1) % 64;
                    wr_f++; if (first_wr_at < 0) first_wr_at = cyc;
                end
                chk(rd_f - wr_f <= DEPTH, "R6", "reads ahead of writes", rd_f - wr_f, DEPTH);
            end
            if (pv && !pr && !abort_prev && !err_prev)
                chk(a_valid && a_address == p_addr && a_opcode == p_op, "R8",
                    "stalled request held", a_address, p_addr);
            if (a_valid)
                chk(a_mask == 4'hF && a_size == 2'd2 && a_source == (a_opcode == 3'd0 ? 2'd1 : 2'd0),
                    "R2", "request fields", {a_mask, a_size, a_source}, 0);
            if (busy) chk(d_ready, "R6", "d_ready while busy", d_ready, 1);
            if (track) begin
                chk(cur_src == t_src + 4*rd_f, "R4", "cur_src", cur_src, t_src + 4*rd_f);
                chk(cur_dst == t_dst + 4*wr_f, "R4", "cur_dst", cur_dst, t_dst + 4*wr_f);
                chk(remaining == t_len - 4*wr_ack, "R4", "remaining", remaining, t_len - 4*wr_ack);
            end
            if (prev_done) chk(!busy && !done, "R5", "idle after done", busy, 0);
            if (done) begin
                done_seen++;
                chk(busy && wr_ack == t_len/4, "R5", "done after last ack", wr_ack, t_len/4);
            end
            prev_done = done;
        end
        // drive next cycle
        pv = a_valid; p_op = a_opcode; p_addr = a_address; p_data = a_data;
        case (rdy_mode)
            0: pr = 1'b1;
            1: pr = cyc[0];
            default: pr = ((cyc * 7) % 5) != 0;
        endcase
        a_ready = pr;
        abort_prev = abort;
        dp = 1'b0; err_prev = 1'b0;
        d_valid = 1'b0; d_error = 1'b0;
        if (qh != qt && cyc - q_t[qh] >= lat && (rdy_mode != 2 || (cyc % 3) != 0)) begin
            d_valid = 1'b1; d_data = q_d[qh]; d_source = q_wr[qh] ? 2'd1 : 2'd0;
            d_error = (resp_n == err_at);
            err_prev = d_error;
            dp = 1'b1; dp_wr = q_wr[qh];
            resp_n++; qh = (qh + 1) % 64;
        end
    end

    task automatic run_copy(input int sw, input int dw, input int n, input int mode,
                            input int l, input int abort_at, input int e_at,
                            input int sb_at, input string tag);
        for (int i = 0; i < 256; i++) mem[i] = pat(i);
        rdy_mode = mode; lat = l; err_at = e_at;
        @(posedge clk); #2;
        track = 0; rd_f = 0; wr_f = 0; wr_ack = 0; resp_n = 0; done_seen = 0;
        first_wr_at = -1; last_rd_at = -1;
        t_src = sw * 4; t_dst = dw * 4; t_len = n * 4;
        src_addr = t_src; dst_addr = t_dst; byte_len = t_len; start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0; track = 1;
        for (int k = 0; k < 3000; k++) begin
            if (k == abort_at) abort = 1'b1;
            if (k == sb_at) begin start = 1'b1; src_addr = 32'h200; dst_addr = 32'h300; byte_len = 32'h40; end
            @(posedge clk); #2;
            abort = 1'b0; start = 1'b0;
            if (!busy) break;
        end
        chk(!busy, "R5", {tag, " engine returned idle"}, busy, 0);
        @(negedge clk); #1;
        if (abort_at < 0 && e_at < 0) begin
            chk(done_seen == 1, "R5", {tag, " single done"}, done_seen, 1);
            chk(rd_f == n && wr_f == n, "R3", {tag, " transfer counts"}, wr_f, n);
            for (int k = 0; k < n; k++)
                chk(mem[dw + k] == pat(sw + k), "R3", {tag, " copied word"}, mem[dw + k], pat(sw + k));
            chk(mem[dw + n] == pat(dw + n), "R3", {tag, " word after buffer"}, mem[dw + n], pat(dw + n));
            chk(!err, "R10", {tag, " err clear"}, err, 0);
            if (n > DEPTH && mode == 0)
                chk(first_wr_at < last_rd_at, "R7", {tag, " reads and writes interleaved"}, first_wr_at, last_rd_at);
        end else if (abort_at >= 0) begin
            chk(done_seen == 0, "R9", {tag, " no done on abort"}, done_seen, 0);
            chk(!err, "R9", {tag, " err clear on abort"}, err, 0);
            chk(wr_f < n, "R9", {tag, " copy cut short"}, wr_f, n);
            chk(wr_ack == wr_f && qh == qt, "R9", {tag, " responses drained"}, wr_ack, wr_f);
        end else begin
            chk(done_seen == 0, "R10", {tag, " no done on error"}, done_seen, 0);
            chk(err, "R10", {tag, " err set"}, err, 1);
            chk(qh == qt, "R10", {tag, " responses drained"}, qt - qh, 0);
        end
        track = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err && !a_valid, "R1", "reset flags", {busy, done, err, a_valid}, 0);
        chk(cur_src == 0 && cur_dst == 0 && remaining == 0, "R1", "reset values", cur_src | cur_dst | remaining, 0);

        for (int n = 0; n < 10; n++)
            for (int m = 0; m < 3; m++)
                for (int li = 0; li < 2; li++)
                    run_copy(8 + n, 100 + 2*n, n, m, li ? 4 : 1, -1, -1, -1, "sweep");
        chk(1'b1, "R3", "zero length included in sweep", 0, 0);

        // R11: start while busy ignored
        run_copy(20, 150, 9, 1, 2, -1, -1, 5, "restart_r11");
        // R9: abort mid copy
        run_copy(10, 120, 20, 0, 3, 6, -1, -1, "abort_r9");
        run_copy(10, 120, 20, 2, 1, 10, -1, -1, "abort2_r9");
        // R10: error response
        run_copy(30, 200, 8, 0, 2, -1, 2, -1, "error_r10");
        // R10: err clears on next start
        run_copy(30, 200, 6, 0, 1, -1, -1, -1, "after_err_r10");

        // R9: abort while idle
        @(posedge clk); #2 abort = 1'b1;
        @(posedge clk); #2 abort = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        chk(!busy && !a_valid, "R9", "abort while idle", busy, 0);
        chk(cur_dst == 200*4 + 6*4, "R9", "idle abort keeps cur_dst", cur_dst, 200*4 + 6*4);
        chk(remaining == 0, "R9", "idle abort keeps remaining", remaining, 0);

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule